// File: doc/BRIEF.md
# Memory-Mapped IDE Register Window

This block connects a host bus with byte, halfword and word accesses to the task-file registers of an IDE channel. A 4 KB window is split into 16-byte register slots. Byte accesses reach the command and control registers. Halfword and word accesses reach the data port. When the host is big-endian, the byte lanes of data-port transfers are reversed. Slots that nothing occupies, and mapped slots used at the wrong width, read as all ones and ignore writes.

The block contains a small model of the downstream register file: six byte registers, a command register, a device-control register and a 32-bit data latch. The device status byte comes in on an input. The command register reports each write on a one-cycle command strobe. A device-side event sets a pending interrupt. The interrupt line toward the interrupt controller is a level signal. The interrupt-disable bit in device control masks it, and a read of the main status register clears it.

Top module: `ide_mmio_window`

## Requirements
- R1: The slot number is `host_addr[11:4]`. Address bits above bit 11 and below bit 4 do not change which register an access reaches.
- R2: Byte accesses to slots 1 to 6 write and read back six independent 8-bit registers. A byte read of slot 7 returns `dev_status`. A byte write to slot 7 pulses `cmd_valid` for one cycle with `cmd_code` equal to the written byte.
- R3: Slots 8 and 22 both reach device control. A byte write stores the byte on `dev_ctrl`. A byte read returns `dev_status` as alternate status.
- R4: A byte read of slot 0 returns 0x000000FF. A byte write to slot 0 leaves the data latch unchanged.
- R5: With `big_endian` low, a word write to slot 0 stores all 32 bits and a word read returns them. A halfword write stores the low 16 bits and clears the upper half. A halfword read returns bits [15:0], zero-extended.
- R6: With `big_endian` high, data-port transfers are byte-reversed on both writes and reads. A word write of 0x11223344 is stored as 0x44332211. A halfword write of 0xA1B2 is stored as 0xB2A1.
- R7: Three cases count as unmapped:
  - any slot other than 0, 1 to 7, 8 and 22;
  - any non-byte access to slots 1 to 22;
  - any access with `host_size` equal to 3.

  An unmapped read returns all ones at the access width: 0x000000FF for a byte, 0x0000FFFF for a halfword, 0xFFFFFFFF for a word or for size 3. An unmapped write changes nothing.
- R8: Read data appears on `host_rdata` in the cycle after the read is accepted. `host_rdata` holds its value until the next read.
- R9: `dev_irq_set` sets a pending flag. `irq_out` is high while the flag is set and `dev_ctrl` bit 1 is clear.
- R10: A byte read of slot 7 clears the pending flag. If `dev_irq_set` is high in the same cycle, the flag stays set.
- R11: A read of alternate status (slot 8 or 22) does not clear the pending flag.
- R12: Setting `dev_ctrl` bit 1 drops `irq_out` but keeps the pending flag. Clearing the bit raises `irq_out` again if the flag is still set.
- R13: Synchronous reset clears the following:
  - `host_rdata`, `dev_ctrl` and `cmd_valid`;
  - the pending flag, so `irq_out` is low;
  - the data latch and the six byte registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Host byte order; 1 selects lane reversal on the data port |
| host_valid | input | 1 | Access strobe; every access completes in one cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Write data, right-aligned |
| host_rdata | output | 32 | Registered read data |
| dev_status | input | 8 | Device status byte |
| dev_irq_set | input | 1 | Device interrupt event |
| dev_ctrl | output | 8 | Device-control register |
| cmd_valid | output | 1 | One-cycle strobe on a command write |
| cmd_code | output | 8 | Last command byte written |
| irq_out | output | 1 | Level interrupt request |

## Verification
Two interrupt functions can act in the same cycle: a device event setting the pending flag, and a status read clearing it. The bench provokes this collision by raising `dev_irq_set` in the very cycle it issues a byte read of slot 7. It then checks that `irq_out` stays high afterwards, and that a later status read without an event does drop the line. Masking is checked in the same sequence. The bench toggles the disable bit while the flag is pending and watches the line fall and return.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

    localparam int HOST_DW     = 32;
    localparam int SLOT_LSB    = 4;
    localparam int SLOT_W      = 8;
    localparam int WIN_AW      = SLOT_LSB + SLOT_W;
    localparam int SLOT_DATA   = 0;
    localparam int TF_FIRST    = 1;
    localparam int TF_LAST     = 6;
    localparam int SLOT_STATUS = 7;
    localparam int CTRL_SLOT_A = 8;
    localparam int CTRL_SLOT_B = 22;
    localparam int IRQ_DIS_BIT = 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_TASKFILE,
        TGT_STATUS,
        TGT_CTRL,
        TGT_DATA
    } acc_tgt_e;

    typedef struct packed {
        logic      rd;
        logic      wr;
        acc_tgt_e  tgt;
        logic [2:0] reg_idx;
        acc_size_e size;
    } acc_t;

    function automatic logic [15:0] swap16(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    function automatic logic [31:0] swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [HOST_DW-1:0] lane_swap(input acc_size_e sz,
                                                     input logic [HOST_DW-1:0] v);
        if (sz == SZ_HALF) return {16'h0000, swap16(v[15:0])};
        return swap32(v);
    endfunction

    function automatic logic [HOST_DW-1:0] ones_for(input acc_size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
    import ide_win_pkg::*;
(
    input  logic                       valid,
    input  logic                       write,
    input  logic [1:0]                 size,
    input  logic [WIN_AW-1:SLOT_LSB]   slot,
    output acc_t                       acc
);

    acc_size_e sz;
    logic      is_tf;
    logic      is_ctrl;

    assign sz      = acc_size_e'(size);
    assign is_tf   = (slot >= SLOT_W'(TF_FIRST)) && (slot <= SLOT_W'(TF_LAST));
    assign is_ctrl = (slot == SLOT_W'(CTRL_SLOT_A)) || (slot == SLOT_W'(CTRL_SLOT_B));

    always_comb begin
        acc.rd      = valid && !write;
        acc.wr      = valid && write;
        acc.size    = sz;
        acc.reg_idx = slot[SLOT_LSB+2:SLOT_LSB];
        acc.tgt     = TGT_NONE;
        case (sz)
            SZ_BYTE: begin
                if (is_tf)                                acc.tgt = TGT_TASKFILE;
                else if (slot == SLOT_W'(SLOT_STATUS))    acc.tgt = TGT_STATUS;
                else if (is_ctrl)                         acc.tgt = TGT_CTRL;
            end
            SZ_HALF, SZ_WORD: begin
                if (slot == SLOT_W'(SLOT_DATA))           acc.tgt = TGT_DATA;
            end
            default: acc.tgt = TGT_NONE;
        endcase
    end

endmodule

// File: rtl/ide_win_taskfile.sv
module ide_win_taskfile
    import ide_win_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  acc_t               acc,
    input  logic [HOST_DW-1:0] wdata,
    input  logic [7:0]         dev_status,
    output logic [HOST_DW-1:0] rdata,
    output logic [7:0]         dev_ctrl,
    output logic               cmd_valid,
    output logic [7:0]         cmd_code
);

    logic [7:0]         tf_q [TF_LAST:TF_FIRST];
    logic [HOST_DW-1:0] data_q;

    for (genvar g = TF_FIRST; g <= TF_LAST; g++) begin : g_tf
        always_ff @(posedge clk) begin
            if (rst)
                tf_q[g] <= 8'h00;
            else if (acc.wr && acc.tgt == TGT_TASKFILE && acc.reg_idx == 3'(g))
                tf_q[g] <= wdata[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            dev_ctrl  <= 8'h00;
            cmd_valid <= 1'b0;
            cmd_code  <= 8'h00;
        end else begin
            cmd_valid <= acc.wr && acc.tgt == TGT_STATUS;
            if (acc.wr && acc.tgt == TGT_STATUS) cmd_code <= wdata[7:0];
            if (acc.wr && acc.tgt == TGT_CTRL)   dev_ctrl <= wdata[7:0];
            if (acc.wr && acc.tgt == TGT_DATA) begin
                if (acc.size == SZ_HALF) data_q <= {16'h0000, wdata[15:0]};
                else                     data_q <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (acc.tgt)
            TGT_TASKFILE: begin
                for (int i = TF_FIRST; i <= TF_LAST; i++)
                    if (acc.reg_idx == 3'(i)) rdata = {24'h0, tf_q[i]};
            end
            TGT_STATUS, TGT_CTRL: rdata = {24'h0, dev_status};
            TGT_DATA: rdata = (acc.size == SZ_HALF) ? {16'h0000, data_q[15:0]} : data_q;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/ide_win_irq.sv
module ide_win_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic mask,
    output logic pending,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst)          pending <= 1'b0;
        else if (set_evt) pending <= 1'b1;
        else if (clr_evt) pending <= 1'b0;
    end

    assign irq = pending && !mask;

endmodule

// File: rtl/ide_mmio_window.sv
module ide_mmio_window
    import ide_win_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               big_endian,
    input  logic               host_valid,
    input  logic               host_write,
    input  logic [1:0]         host_size,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic [7:0]         dev_status,
    input  logic               dev_irq_set,
    output logic [7:0]         dev_ctrl,
    output logic               cmd_valid,
    output logic [7:0]         cmd_code,
    output logic               irq_out
);

    acc_t               acc;
    logic [HOST_DW-1:0] wdata_dev;
    logic [HOST_DW-1:0] rdata_dev;
    logic [HOST_DW-1:0] rd_val;
    logic               irq_pending;
    logic               unused_addr_bits;

    assign unused_addr_bits = ^{host_addr[ADDR_W-1:WIN_AW], host_addr[SLOT_LSB-1:0]};

    ide_win_decode u_dec (
        .valid (host_valid),
        .write (host_write),
        .size  (host_size),
        .slot  (host_addr[WIN_AW-1:SLOT_LSB]),
        .acc   (acc)
    );

    assign wdata_dev = (big_endian && acc.tgt == TGT_DATA) ? lane_swap(acc.size, host_wdata)
                                                           : host_wdata;

    ide_win_taskfile u_tf (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .wdata      (wdata_dev),
        .dev_status (dev_status),
        .rdata      (rdata_dev),
        .dev_ctrl   (dev_ctrl),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code)
    );

    always_comb begin
        if (acc.tgt == TGT_NONE)
            rd_val = ones_for(acc.size);
        else if (big_endian && acc.tgt == TGT_DATA)
            rd_val = lane_swap(acc.size, rdata_dev);
        else
            rd_val = rdata_dev;
    end

    always_ff @(posedge clk) begin
        if (rst)         host_rdata <= '0;
        else if (acc.rd) host_rdata <= rd_val;
    end

    ide_win_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_evt (dev_irq_set),
        .clr_evt (acc.rd && acc.tgt == TGT_STATUS),
        .mask    (dev_ctrl[IRQ_DIS_BIT]),
        .pending (irq_pending),
        .irq     (irq_out)
    );

endmodule

// File: rtl/ide_mmio_window_chk.sv
module ide_mmio_window_chk
    import ide_win_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              host_valid,
    input logic              host_write,
    input logic [1:0]        host_size,
    input logic [ADDR_W-1:0] host_addr,
    input logic [31:0]       host_rdata,
    input logic              dev_irq_set,
    input logic [7:0]        dev_ctrl,
    input logic              cmd_valid,
    input logic              irq_out,
    input logic              irq_pending
);

    logic [SLOT_W-1:0] slot;
    logic              rd;
    assign slot = host_addr[WIN_AW-1:SLOT_LSB];
    assign rd   = host_valid && !host_write;

    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(host_rdata));

    a_r4_slot0_byte: assert property (@(posedge clk) disable iff (rst)
        (rd && host_size == 2'd0 && slot == 8'd0) |=> host_rdata == 32'h0000_00FF);

    a_r7_wide_unmapped: assert property (@(posedge clk) disable iff (rst)
        (rd && host_size == 2'd2 && slot != 8'd0) |=> host_rdata == 32'hFFFF_FFFF);

    a_r2_cmd_strobe: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(host_valid && host_write && host_size == 2'd0 && slot == 8'd7));

    a_r9_event_sets: assert property (@(posedge clk) disable iff (rst)
        dev_irq_set |=> irq_pending);

    a_r10_status_clears: assert property (@(posedge clk) disable iff (rst)
        (rd && host_size == 2'd0 && slot == 8'd7 && !dev_irq_set) |=> !irq_pending);

    a_r11_alt_keeps: assert property (@(posedge clk) disable iff (rst)
        (rd && host_size == 2'd0 && (slot == 8'd8 || slot == 8'd22) && irq_pending) |=> irq_pending);

    a_r12_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        dev_ctrl[1] |-> !irq_out);

endmodule

bind ide_mmio_window ide_mmio_window_chk u_chk (.*);

// File: tb/ide_mmio_window_tb.sv
module ide_mmio_window_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        big_endian;
    logic        host_valid;
    logic        host_write;
    logic [1:0]  host_size;
    logic [31:0] host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic [7:0]  dev_status;
    logic        dev_irq_set;
    logic [7:0]  dev_ctrl;
    logic        cmd_valid;
    logic [7:0]  cmd_code;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  m_tf [1:6];
    logic [31:0] m_data;
    logic [7:0]  m_ctrl;
    logic        m_pend;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    ide_mmio_window u_dut (
        .clk(clk), .rst(rst), .big_endian(big_endian),
        .host_valid(host_valid), .host_write(host_write), .host_size(host_size),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_status(dev_status), .dev_irq_set(dev_irq_set), .dev_ctrl(dev_ctrl),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .irq_out(irq_out)
    );

    function automatic logic [31:0] sw32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int slot, input int sz, input bit be);
        logic [31:0] d;
        if (sz == 0) begin
            if (slot >= 1 && slot <= 6)                  return {24'h0, m_tf[slot]};
            if (slot == 7 || slot == 8 || slot == 22)    return {24'h0, dev_status};
            return 32'h0000_00FF;
        end
        if (sz == 1) begin
            if (slot != 0) return 32'h0000_FFFF;
            d = {16'h0, m_data[15:0]};
            return be ? {16'h0, d[7:0], d[15:8]} : d;
        end
        if (sz == 2) begin
            if (slot != 0) return 32'hFFFF_FFFF;
            return be ? sw32(m_data) : m_data;
        end
        return 32'hFFFF_FFFF;
    endfunction

    // one access: drive at negedge, sample at the following negedge
    task automatic access(input bit wr, input int sz, input int slot,
                          input logic [31:0] wd, input bit evt);
        logic [31:0] r = next_rand();
        @(negedge clk);
        host_valid  = 1'b1;
        host_write  = wr;
        host_size   = 2'(sz);
        host_addr   = {r[31:12], 8'(slot), r[3:0]};
        host_wdata  = wd;
        dev_irq_set = evt;
        @(negedge clk);
        host_valid  = 1'b0;
        dev_irq_set = 1'b0;
        if (evt) m_pend = 1'b1;
        else if (!wr && sz == 0 && slot == 7) m_pend = 1'b0;
        if (wr) begin
            if (sz == 0 && slot >= 1 && slot <= 6) m_tf[slot] = wd[7:0];
            if (sz == 0 && (slot == 8 || slot == 22)) m_ctrl = wd[7:0];
            if (sz == 1 && slot == 0)
                m_data = {16'h0, big_endian ? {wd[7:0], wd[15:8]} : wd[15:0]};
            if (sz == 2 && slot == 0) m_data = big_endian ? sw32(wd) : wd;
        end
    endtask

    task automatic check_irq(input string tag);
        chk(tag, {31'h0, irq_out}, {31'h0, m_pend && !m_ctrl[1]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] keep;
        rst = 1'b1; big_endian = 1'b0; host_valid = 1'b0; host_write = 1'b0;
        host_size = 2'd0; host_addr = '0; host_wdata = '0; dev_status = 8'h50;
        dev_irq_set = 1'b0;
        for (int i = 1; i <= 6; i++) m_tf[i] = 8'h00;
        m_data = '0; m_ctrl = 8'h00; m_pend = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        chk("R13 rdata", host_rdata, 32'h0);
        chk("R13 ctrl", {24'h0, dev_ctrl}, 32'h0);
        chk("R13 cmd_valid", {31'h0, cmd_valid}, 32'h0);
        chk("R13 irq", {31'h0, irq_out}, 32'h0);
        access(1'b0, 2, 0, 32'h0, 1'b0);
        chk("R13 data latch", host_rdata, 32'h0);

        // R1 R2 R3 R4 R5 R6 R7 sweep: every slot, size, byte order
        for (int be = 0; be < 2; be++) begin
            big_endian = be[0];
            for (int s = 0; s < 33; s++) begin
                int slot = (s == 32) ? 255 : s;
                for (int sz = 0; sz < 4; sz++) begin
                    logic [31:0] wd = next_rand();
                    if (slot == 8 || slot == 22) wd[1] = 1'b0;
                    access(1'b1, sz, slot, wd, 1'b0);
                    chk("R2 cmd_valid", {31'h0, cmd_valid},
                        {31'h0, (sz == 0 && slot == 7)});
                    if (sz == 0 && slot == 7) chk("R2 cmd_code", {24'h0, cmd_code}, {24'h0, wd[7:0]});
                    chk("R3 dev_ctrl", {24'h0, dev_ctrl}, {24'h0, m_ctrl});
                    dev_status = 8'(next_rand());
                    access(1'b0, sz, slot, 32'h0, 1'b0);
                    chk($sformatf("R7 R1 read slot %0d size %0d be %0d", slot, sz, be),
                        host_rdata, exp_read(slot, sz, be[0]));
                    check_irq("R9 idle irq");
                end
            end
            // R4 byte write to slot 0 dropped
            access(1'b1, 2, 0, 32'hCAFE_F00D, 1'b0);
            access(1'b1, 0, 0, 32'h0000_0011, 1'b0);
            access(1'b0, 2, 0, 32'h0, 1'b0);
            chk("R4 byte write dropped", host_rdata, be ? 32'hCAFE_F00D : 32'hCAFE_F00D);
        end

        // R6 cross-order checks through the latch
        big_endian = 1'b1;
        access(1'b1, 2, 0, 32'h1122_3344, 1'b0);
        big_endian = 1'b0;
        access(1'b0, 2, 0, 32'h0, 1'b0);
        chk("R6 word swap on write", host_rdata, 32'h4433_2211);
        big_endian = 1'b1;
        access(1'b1, 1, 0, 32'h0000_A1B2, 1'b0);
        big_endian = 1'b0;
        access(1'b0, 1, 0, 32'h0, 1'b0);
        chk("R6 half swap on write", host_rdata, 32'h0000_B2A1);
        access(1'b1, 2, 0, 32'h5566_7788, 1'b0);
        big_endian = 1'b1;
        access(1'b0, 2, 0, 32'h0, 1'b0);
        chk("R6 word swap on read", host_rdata, 32'h8877_6655);
        access(1'b0, 1, 0, 32'h0, 1'b0);
        chk("R5 R6 half read", host_rdata, 32'h0000_8877);
        big_endian = 1'b0;

        // R8 hold
        keep = host_rdata;
        access(1'b1, 0, 3, 32'h77, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8 rdata held", host_rdata, keep);

        // interrupt sequence
        access(1'b1, 0, 8, 32'h00, 1'b0);
        access(1'b1, 0, 3, 32'h00, 1'b1);
        chk("R9 event raises irq", {31'h0, irq_out}, 32'h1);
        access(1'b0, 0, 22, 32'h0, 1'b0);
        chk("R11 alt read keeps irq", {31'h0, irq_out}, 32'h1);
        access(1'b0, 0, 8, 32'h0, 1'b0);
        chk("R11 alt read slot 8 keeps irq", {31'h0, irq_out}, 32'h1);
        access(1'b1, 0, 22, 32'h02, 1'b0);
        chk("R12 mask drops irq", {31'h0, irq_out}, 32'h0);
        access(1'b1, 0, 8, 32'h00, 1'b0);
        chk("R12 unmask restores irq", {31'h0, irq_out}, 32'h1);
        access(1'b0, 0, 7, 32'h0, 1'b1);
        chk("R10 event beats status read", {31'h0, irq_out}, 32'h1);
        access(1'b0, 0, 7, 32'h0, 1'b0);
        chk("R10 status read clears", {31'h0, irq_out}, 32'h0);
        access(1'b1, 0, 8, 32'h02, 1'b1);
        check_irq("R12 masked pending");
        access(1'b0, 0, 7, 32'h0, 1'b0);
        access(1'b1, 0, 8, 32'h00, 1'b0);
        chk("R10 cleared while masked", {31'h0, irq_out}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule